// File: doc/BRIEF.md
# Serial EEPROM Burst Loader

This controller sits between a host register bus and an external byte-wide EEPROM. Through it the host can fetch one byte from any EEPROM location or store one byte there. Each request bit clears itself when the transfer completes. The host can also launch a burst. A burst walks the EEPROM as a list of three-byte records, and each record becomes one byte write into a 24-bit internal memory space. A record holds a 16-bit target offset, low byte first, and then a data byte.

The host chooses the upper nine bits of every burst target through a base register. The lower fifteen bits come from the offset stored in the record, and the offset's top bit is dropped. A record whose offset is all ones ends the burst. A burst launched after reset, before any other EEPROM access, begins at EEPROM address 0. In every other case it begins one past the last EEPROM byte touched, whether a single access or an earlier burst touched it. While any operation is running the controller is busy, and every host register write is discarded.

The EEPROM side is a request/acknowledge port. The memory side is a write-only strobe with address and data.

Top module: `eeprom_burst_loader`

## Requirements
- R1: After reset every host register reads 0 (index 0 launch, 1 control, 2 EEPROM address, 3 data byte, 4 base; indices 5 to 7 always read 0), `ee_req` is low and `mem_we` is low.
- R2: Writing the control register (index 1) with bit 1 set reads one byte from the location in the address register into the data register. Control bit 1 reads 1 until the byte is in the data register and then clears itself. If bits 1 and 0 are both set, only the read takes place.
- R3: Writing the control register with bit 0 set (and bit 1 clear) stores the data register into the EEPROM location in the address register. Control bit 0 reads 1 until the store completes and then clears itself.
- R4: Control bit 2 reads 1 while any single access or burst is running. Every host register write made while busy is ignored, including new requests and writes to the address, data and base registers.
- R5: Writing bit 0 of the launch register (index 0) starts a burst. That bit reads 1 while the burst runs and clears itself when the burst ends.
- R6: A burst begins at EEPROM address 0 if no EEPROM access has happened since reset. Otherwise it begins at the address after the last one accessed, and the 16-bit address wraps from 0xFFFF to 0x0000.
- R7: Each burst record is read as offset low byte, offset high byte, data byte. It produces one memory write of the data byte to {base[8:0], offset[14:0]}, so offset bit 15 is discarded. Memory writes follow EEPROM order.
- R8: A record whose offset is 0xFFFF ends the burst. Its data byte is not read, and it produces no memory write. A burst of n data records therefore makes 3n+2 EEPROM reads.
- R9: `ee_req` stays high with `ee_addr`, `ee_we` and `ee_wdata` unchanged until the cycle in which `ee_ack` is high. `mem_we` is a one-cycle pulse in the cycle after the acknowledge of a record's data byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Host register write strobe |
| reg_idx | input | 3 | Host register index |
| reg_wdata | input | 16 | Host write data |
| reg_rdata | output | 16 | Readback of the indexed register (combinational) |
| ee_req | output | 1 | EEPROM byte request |
| ee_we | output | 1 | 1 = store, 0 = fetch |
| ee_addr | output | 16 | EEPROM byte address |
| ee_wdata | output | 8 | Byte to store |
| ee_rdata | input | 8 | Fetched byte, valid with `ee_ack` |
| ee_ack | input | 1 | Request complete |
| mem_we | output | 1 | Memory write strobe |
| mem_addr | output | 24 | Memory write address |
| mem_wdata | output | 8 | Memory write data |

## Verification
Register readback is combinational, so the bench reads it one time unit after a falling edge. A request written at a rising edge is visible as pending at the next falling edge, and the bench checks the pending and busy bits there. The EEPROM model acknowledges after a latency the bench chooses at random, so completion times vary. For that reason the bench polls busy at each falling edge instead of counting a fixed number of cycles, and compares results only once busy has cleared. Memory writes land one cycle after each data acknowledge and always before busy drops. The model also logs the address it sees when each request first appears and flags any request whose address changes before the acknowledge.

// File: rtl/eebl_pkg.sv
package eebl_pkg;

   localparam int unsigned REG_IDX_W = 3;

   localparam logic [REG_IDX_W-1:0] IDX_LAUNCH = 3'd0;
   localparam logic [REG_IDX_W-1:0] IDX_CTRL   = 3'd1;
   localparam logic [REG_IDX_W-1:0] IDX_ADDR   = 3'd2;
   localparam logic [REG_IDX_W-1:0] IDX_DATA   = 3'd3;
   localparam logic [REG_IDX_W-1:0] IDX_BASE   = 3'd4;

   // control register bit positions (host software decodes these)
   localparam int unsigned CTRL_STORE_BIT = 0;
   localparam int unsigned CTRL_FETCH_BIT = 1;
   localparam int unsigned CTRL_BUSY_BIT  = 2;
   localparam int unsigned LAUNCH_BIT     = 0;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_FETCH1,
      ST_STORE1,
      ST_REC_LO,
      ST_REC_HI,
      ST_REC_DAT
   } eebl_state_e;

endpackage

// File: rtl/eebl_hostregs.sv
module eebl_hostregs
   import eebl_pkg::*;
#(
   parameter int unsigned EE_AW   = 16,
   parameter int unsigned DW      = 8,
   parameter int unsigned BASE_W  = 9,
   parameter int unsigned HOST_DW = 16
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 reg_wr,
   input  logic [REG_IDX_W-1:0] reg_idx,
   input  logic [HOST_DW-1:0]   reg_wdata,
   output logic [HOST_DW-1:0]   reg_rdata,
   input  logic                 busy,
   input  logic                 burst_act,
   input  logic                 fetch_pend,
   input  logic                 store_pend,
   input  logic                 fetch_done,
   input  logic [DW-1:0]        fetch_byte,
   output logic [EE_AW-1:0]     addr_q,
   output logic [DW-1:0]        data_q,
   output logic [BASE_W-1:0]    base_q,
   output logic                 launch_go,
   output logic                 fetch_go,
   output logic                 store_go
);

   logic wr_ok;
   assign wr_ok = reg_wr && !busy;

   assign launch_go = wr_ok && (reg_idx == IDX_LAUNCH) && reg_wdata[LAUNCH_BIT];
   assign fetch_go  = wr_ok && (reg_idx == IDX_CTRL) && reg_wdata[CTRL_FETCH_BIT];
   assign store_go  = wr_ok && (reg_idx == IDX_CTRL) && reg_wdata[CTRL_STORE_BIT]
                      && !reg_wdata[CTRL_FETCH_BIT];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         addr_q <= '0;
         data_q <= '0;
         base_q <= '0;
      end else begin
         if (wr_ok && (reg_idx == IDX_ADDR)) addr_q <= reg_wdata[EE_AW-1:0];
         if (wr_ok && (reg_idx == IDX_BASE)) base_q <= reg_wdata[BASE_W-1:0];
         if (fetch_done)                     data_q <= fetch_byte;
         else if (wr_ok && (reg_idx == IDX_DATA)) data_q <= reg_wdata[DW-1:0];
      end
   end

   always_comb begin
      reg_rdata = '0;
      if (reg_idx == IDX_LAUNCH)    reg_rdata = HOST_DW'(burst_act);
      else if (reg_idx == IDX_CTRL) reg_rdata = HOST_DW'({busy, fetch_pend, store_pend});
      else if (reg_idx == IDX_ADDR) reg_rdata = HOST_DW'(addr_q);
      else if (reg_idx == IDX_DATA) reg_rdata = HOST_DW'(data_q);
      else if (reg_idx == IDX_BASE) reg_rdata = HOST_DW'(base_q);
   end

   AST_BUSY_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && reg_wr) |=> ($stable(addr_q) && $stable(base_q))); // R4

endmodule

// File: rtl/eebl_ptr.sv
module eebl_ptr #(
   parameter int unsigned EE_AW = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic             step,
   input  logic             touch,
   input  logic [EE_AW-1:0] touch_addr,
   output logic [EE_AW-1:0] ptr
);

   localparam logic [EE_AW-1:0] ONE = EE_AW'(1);

   logic             fresh_q;
   logic [EE_AW-1:0] last_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         fresh_q <= 1'b1;
         last_q  <= '0;
         ptr     <= '0;
      end else begin
         if (load) ptr <= fresh_q ? '0 : last_q + ONE;
         if (step) begin
            last_q  <= ptr;
            ptr     <= ptr + ONE;
            fresh_q <= 1'b0;
         end
         if (touch) begin
            last_q  <= touch_addr;
            fresh_q <= 1'b0;
         end
      end
   end

   AST_FRESH_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (load && fresh_q) |=> (ptr == '0)); // R6

endmodule

// File: rtl/eebl_seq.sv
module eebl_seq
   import eebl_pkg::*;
#(
   parameter int unsigned EE_AW   = 16,
   parameter int unsigned DW      = 8,
   parameter int unsigned BASE_W  = 9,
   parameter int unsigned MEM_AW  = 24,
   parameter bit          MEM_REG = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              launch_go,
   input  logic              fetch_go,
   input  logic              store_go,
   input  logic              ee_ack,
   input  logic [DW-1:0]     ee_rdata,
   input  logic [EE_AW-1:0]  ptr,
   input  logic [EE_AW-1:0]  addr_q,
   input  logic [DW-1:0]     data_q,
   input  logic [BASE_W-1:0] base_q,
   output logic              ee_req,
   output logic              ee_we,
   output logic [EE_AW-1:0]  ee_addr,
   output logic [DW-1:0]     ee_wdata,
   output logic              busy,
   output logic              burst_act,
   output logic              fetch_pend,
   output logic              store_pend,
   output logic              step,
   output logic              touch,
   output logic              fetch_done,
   output logic              mem_we,
   output logic [MEM_AW-1:0] mem_addr,
   output logic [DW-1:0]     mem_wdata
);

   localparam int unsigned LOW_W = MEM_AW - BASE_W;

   eebl_state_e      state_q, state_d;
   logic [DW-1:0]    lo_q;
   logic [LOW_W-1:0] tgt_q;
   logic [EE_AW-1:0] word;
   logic             term_hit, data_hit;

   assign burst_act  = (state_q == ST_REC_LO) || (state_q == ST_REC_HI)
                       || (state_q == ST_REC_DAT);
   assign fetch_pend = (state_q == ST_FETCH1);
   assign store_pend = (state_q == ST_STORE1);
   assign busy       = (state_q != ST_IDLE);

   assign ee_req   = busy;
   assign ee_we    = store_pend;
   assign ee_addr  = burst_act ? ptr : addr_q;
   assign ee_wdata = data_q;

   assign step       = burst_act && ee_ack;
   assign touch      = (fetch_pend || store_pend) && ee_ack;
   assign fetch_done = fetch_pend && ee_ack;

   assign word     = {ee_rdata, lo_q};
   assign term_hit = (state_q == ST_REC_HI) && ee_ack && (&word);
   assign data_hit = (state_q == ST_REC_DAT) && ee_ack;

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         ST_IDLE: begin
            if (fetch_go)       state_d = ST_FETCH1;
            else if (store_go)  state_d = ST_STORE1;
            else if (launch_go) state_d = ST_REC_LO;
         end
         ST_FETCH1, ST_STORE1: if (ee_ack) state_d = ST_IDLE;
         ST_REC_LO:  if (ee_ack) state_d = ST_REC_HI;
         ST_REC_HI:  if (ee_ack) state_d = (&word) ? ST_IDLE : ST_REC_DAT;
         ST_REC_DAT: if (ee_ack) state_d = ST_REC_LO;
         default:    state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         lo_q    <= '0;
         tgt_q   <= '0;
      end else begin
         state_q <= state_d;
         if ((state_q == ST_REC_LO) && ee_ack) lo_q <= ee_rdata;
         if ((state_q == ST_REC_HI) && ee_ack) tgt_q <= word[LOW_W-1:0];
      end
   end

   generate
      if (MEM_REG) begin : g_mem_reg
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               mem_we    <= 1'b0;
               mem_addr  <= '0;
               mem_wdata <= '0;
            end else begin
               mem_we <= data_hit;
               if (data_hit) begin
                  mem_addr  <= {base_q, tgt_q};
                  mem_wdata <= ee_rdata;
               end
            end
         end
      end else begin : g_mem_comb
         assign mem_we    = data_hit;
         assign mem_addr  = {base_q, tgt_q};
         assign mem_wdata = ee_rdata;
      end
   endgenerate

   AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (ee_req && !ee_ack) |=> (ee_req && $stable(ee_addr) && $stable(ee_we)
                               && $stable(ee_wdata))); // R9
   AST_MEM_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we |=> !mem_we); // R9
   AST_TERM_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      term_hit |=> (!busy && !mem_we)); // R8
   AST_FETCH_ISSUE: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && fetch_go) |=> (ee_req && !ee_we)); // R2

endmodule

// File: rtl/eeprom_burst_loader.sv
module eeprom_burst_loader
   import eebl_pkg::*;
#(
   parameter int unsigned EE_AW   = 16,
   parameter int unsigned DW      = 8,
   parameter int unsigned BASE_W  = 9,
   parameter int unsigned MEM_AW  = 24,
   parameter int unsigned HOST_DW = 16,
   parameter bit          MEM_REG = 1'b1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 reg_wr,
   input  logic [REG_IDX_W-1:0] reg_idx,
   input  logic [HOST_DW-1:0]   reg_wdata,
   output logic [HOST_DW-1:0]   reg_rdata,
   output logic                 ee_req,
   output logic                 ee_we,
   output logic [EE_AW-1:0]     ee_addr,
   output logic [DW-1:0]        ee_wdata,
   input  logic [DW-1:0]        ee_rdata,
   input  logic                 ee_ack,
   output logic                 mem_we,
   output logic [MEM_AW-1:0]    mem_addr,
   output logic [DW-1:0]        mem_wdata
);

   localparam int unsigned LOW_W = MEM_AW - BASE_W;

   generate
      if (EE_AW != 2 * DW) begin : g_bad_word
         $error("EE_AW must equal two data bytes");
      end
      if (BASE_W >= MEM_AW || LOW_W >= EE_AW) begin : g_bad_split
         $error("base/offset split must drop at least one offset bit");
      end
      if (HOST_DW < EE_AW || HOST_DW < BASE_W || HOST_DW < 3) begin : g_bad_host
         $error("host data width too narrow for register contents");
      end
   endgenerate

   logic [EE_AW-1:0]  addr_q, ptr;
   logic [DW-1:0]     data_q;
   logic [BASE_W-1:0] base_q;
   logic launch_go, fetch_go, store_go;
   logic busy, burst_act, fetch_pend, store_pend;
   logic step, touch, fetch_done;

   eebl_hostregs #(
      .EE_AW(EE_AW), .DW(DW), .BASE_W(BASE_W), .HOST_DW(HOST_DW)
   ) u_regs (
      .clk(clk), .rst_n(rst_n),
      .reg_wr(reg_wr), .reg_idx(reg_idx), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .busy(busy), .burst_act(burst_act), .fetch_pend(fetch_pend), .store_pend(store_pend),
      .fetch_done(fetch_done), .fetch_byte(ee_rdata),
      .addr_q(addr_q), .data_q(data_q), .base_q(base_q),
      .launch_go(launch_go), .fetch_go(fetch_go), .store_go(store_go)
   );

   eebl_ptr #(.EE_AW(EE_AW)) u_ptr (
      .clk(clk), .rst_n(rst_n),
      .load(launch_go), .step(step), .touch(touch), .touch_addr(addr_q),
      .ptr(ptr)
   );

   eebl_seq #(
      .EE_AW(EE_AW), .DW(DW), .BASE_W(BASE_W), .MEM_AW(MEM_AW), .MEM_REG(MEM_REG)
   ) u_seq (
      .clk(clk), .rst_n(rst_n),
      .launch_go(launch_go), .fetch_go(fetch_go), .store_go(store_go),
      .ee_ack(ee_ack), .ee_rdata(ee_rdata),
      .ptr(ptr), .addr_q(addr_q), .data_q(data_q), .base_q(base_q),
      .ee_req(ee_req), .ee_we(ee_we), .ee_addr(ee_addr), .ee_wdata(ee_wdata),
      .busy(busy), .burst_act(burst_act), .fetch_pend(fetch_pend), .store_pend(store_pend),
      .step(step), .touch(touch), .fetch_done(fetch_done),
      .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata)
   );

endmodule

// File: tb/eeprom_burst_loader_test.sv
module eeprom_burst_loader_test;
   import eebl_pkg::*;

   localparam int CLK_PERIOD = 10;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic reg_wr = 1'b0;
   logic [2:0] reg_idx = '0;
   logic [15:0] reg_wdata = '0;
   logic [15:0] reg_rdata;
   logic ee_req, ee_we, ee_ack;
   logic [15:0] ee_addr;
   logic [7:0] ee_wdata, ee_rdata;
   logic mem_we;
   logic [23:0] mem_addr;
   logic [7:0] mem_wdata;

   int nchk = 0, nfail = 0;
   bit done = 0;
   int lat = 1;
   int wcnt = 0;
   int hold_bad = 0;
   logic [15:0] first_a;
   logic [15:0] nxt = 16'h0000;

   logic [7:0]  emem [logic [15:0]];
   logic [16:0] acc_q[$];
   logic [31:0] mw_q[$];

   always #(CLK_PERIOD/2) clk = ~clk;

   eeprom_burst_loader uut (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_idx(reg_idx),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .ee_req(ee_req), .ee_we(ee_we), .ee_addr(ee_addr), .ee_wdata(ee_wdata),
      .ee_rdata(ee_rdata), .ee_ack(ee_ack),
      .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata)
   );

   function automatic logic [7:0] mval(input logic [15:0] a);
      if (emem.exists(a)) return emem[a];
      return a[7:0] ^ a[15:8] ^ 8'h5A;
   endfunction

   // EEPROM model with programmable acknowledge latency
   always @(posedge clk) begin
      if (!rst_n) begin
         ee_ack   <= 1'b0;
         ee_rdata <= '0;
         wcnt     = 0;
      end else begin
         ee_ack <= 1'b0;
         if (ee_req && !ee_ack) begin
            if (wcnt == 0) first_a = ee_addr;
            else if (ee_addr !== first_a) hold_bad++;
            if (wcnt >= lat) begin
               ee_ack   <= 1'b1;
               ee_rdata <= mval(ee_addr);
               if (ee_we) emem[ee_addr] = ee_wdata;
               acc_q.push_back({ee_we, ee_addr});
               wcnt = 0;
            end else wcnt++;
         end
         if (mem_we) mw_q.push_back({mem_addr, mem_wdata});
      end
   end

   task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
      nchk++;
      if (act !== exp) begin
         nfail++;
         $display("FAIL %s: got %h expected %h", r, act, exp);
      end
   endtask

   task automatic hw(input logic [2:0] idx, input logic [15:0] val);
      @(negedge clk);
      reg_idx = idx; reg_wdata = val; reg_wr = 1'b1;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic hr(input logic [2:0] idx, output logic [15:0] v);
      reg_idx = idx;
      #1;
      v = reg_rdata;
   endtask

   task automatic wait_idle();
      logic [15:0] v;
      for (int i = 0; i < 5000; i++) begin
         @(negedge clk);
         hr(IDX_CTRL, v);
         if (!v[2]) return;
      end
      nchk++; nfail++;
      $display("FAIL R4: busy never cleared got 1 expected 0");
   endtask

   task automatic single_rd(input logic [15:0] a);
      logic [15:0] v;
      logic [7:0] ex;
      ex = mval(a);
      hw(IDX_ADDR, a);
      acc_q.delete();
      hw(IDX_CTRL, 16'h0002);
      hr(IDX_CTRL, v);
      chk("R2 fetch pending+busy", v, 16'h0006);
      wait_idle();
      hr(IDX_CTRL, v);
      chk("R2 fetch bit cleared", v, 16'h0000);
      hr(IDX_DATA, v);
      chk("R2 fetched byte", v, {8'h00, ex});
      chk("R2 one fetch access", acc_q.size(), 1);
      if (acc_q.size() > 0) chk("R2 fetch address", acc_q[0], {1'b0, a});
      nxt = a + 16'd1;
   endtask

   task automatic single_wr(input logic [15:0] a, input logic [7:0] d);
      logic [15:0] v;
      hw(IDX_ADDR, a);
      hw(IDX_DATA, {8'h00, d});
      acc_q.delete();
      hw(IDX_CTRL, 16'h0001);
      hr(IDX_CTRL, v);
      chk("R3 store pending+busy", v, 16'h0005);
      wait_idle();
      hr(IDX_CTRL, v);
      chk("R3 store bit cleared", v, 16'h0000);
      chk("R3 stored byte", mval(a), d);
      chk("R3 one store access", acc_q.size(), 1);
      if (acc_q.size() > 0) chk("R3 store address", acc_q[0], {1'b1, a});
      nxt = a + 16'd1;
   endtask

   task automatic burst(input int n, input logic [8:0] base, input bit poke);
      logic [31:0] ex[$];
      logic [15:0] p, s, ra, v, old_a, old_d;
      logic [7:0]  d;
      s = nxt; p = s;
      for (int i = 0; i < n; i++) begin
         ra = 16'($urandom);
         if (ra == 16'hFFFF) ra = 16'hC0DE;
         d = 8'($urandom);
         emem[p] = ra[7:0]; emem[p + 16'd1] = ra[15:8]; emem[p + 16'd2] = d;
         ex.push_back({base, ra[14:0], d});
         p = p + 16'd3;
      end
      emem[p] = 8'hFF; emem[p + 16'd1] = 8'hFF;
      hw(IDX_BASE, {7'd0, base});
      hr(IDX_ADDR, old_a);
      hr(IDX_DATA, old_d);
      acc_q.delete(); mw_q.delete();
      hw(IDX_LAUNCH, 16'h0001);
      hr(IDX_LAUNCH, v);
      chk("R5 launch bit set while running", v, 16'h0001);
      if (poke) begin
         hr(IDX_CTRL, v);
         chk("R4 busy only during burst", v, 16'h0004);
         hw(IDX_ADDR, 16'h1234);
         hw(IDX_CTRL, 16'h0003);
         hw(IDX_LAUNCH, 16'h0001);
         hw(IDX_BASE, 16'h00AA);
         hw(IDX_DATA, 16'h0077);
      end
      wait_idle();
      hr(IDX_LAUNCH, v);
      chk("R5 launch bit self-cleared", v, 16'h0000);
      chk("R8 access count 3n+2", acc_q.size(), 3 * n + 2);
      if (acc_q.size() > 0) chk("R6 burst start address", acc_q[0], {1'b0, s});
      for (int i = 0; i < acc_q.size(); i++)
         if (acc_q[i][16]) chk("R8 burst made a store", 1, 0);
      chk("R9 one mem pulse per record", mw_q.size(), n);
      for (int i = 0; i < n && i < mw_q.size(); i++)
         chk("R7 memory write", mw_q[i], ex[i]);
      if (poke) begin
         hr(IDX_ADDR, v);
         chk("R4 addr write ignored", v, old_a);
         hr(IDX_DATA, v);
         chk("R4 data write ignored", v, old_d);
         hr(IDX_BASE, v);
         chk("R4 base write ignored", v, {7'd0, base});
      end
      nxt = p + 16'd2;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         nfail++;
         $display("FAIL watchdog: run did not finish got 0 expected 1");
         $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
         $finish;
      end
   end

   initial begin
      logic [15:0] v;
      logic [7:0] pre;
      int unsigned seed;
      seed = $urandom(32'd20501);
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      for (int i = 0; i < 8; i++) begin
         hr(3'(i), v);
         chk("R1 register reset value", v, 16'h0000);
      end
      chk("R1 no request after reset", ee_req, 1'b0);
      chk("R1 no memory write after reset", mem_we, 1'b0);

      lat = 1;
      burst(2, 9'h1AB, 1'b0);   // first burst after reset: starts at 0 (R6)
      burst(0, 9'h003, 1'b0);   // continues after previous burst, terminator only (R8)
      single_rd(16'h0300);
      burst(1, 9'h155, 1'b0);   // starts at 0x0301 (R6)
      single_wr(16'h0400, 8'hC3);
      single_rd(16'h0400);

      // both request bits: fetch only (R2)
      pre = mval(16'h0500);
      hw(IDX_ADDR, 16'h0500);
      hw(IDX_DATA, 16'h0011);
      acc_q.delete();
      hw(IDX_CTRL, 16'h0003);
      wait_idle();
      hr(IDX_DATA, v);
      chk("R2 both bits fetches", v, {8'h00, pre});
      chk("R2 both bits no store", mval(16'h0500), pre);
      chk("R2 both bits single access", acc_q.size(), 1);
      nxt = 16'h0501;

      lat = 3;
      burst(4, 9'h0F0, 1'b1);   // writes during busy ignored (R4)

      // address wrap (R6)
      lat = 0;
      single_rd(16'hFFFE);
      burst(1, 9'h1FF, 1'b0);
      if (acc_q.size() > 1) chk("R6 wrap to 0x0000", acc_q[1], 17'h00000);

      for (int it = 0; it < 24; it++) begin
         lat = $urandom % 4;
         case ($urandom % 3)
            0: single_wr(16'($urandom), 8'($urandom));
            1: single_rd(16'($urandom));
            default: burst($urandom % 4, 9'($urandom), 1'b0);
         endcase
      end

      chk("R9 request held until acknowledge", hold_bad, 0);
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
   end

endmodule